// File: doc/BRIEF.md
# Sequential Implication-Logic Carry-Save Adder

This block adds three small unsigned operands. It uses no combinational adder. All arithmetic runs through a bank of single-bit state cells that allow only two operations:
- a clear of a contiguous range of cells;
- a material implication, where the destination cell becomes `(NOT source) OR destination`.

A fixed schedule applies one of these operations per clock, so every XOR, AND and OR is built from ordered, destructive implication steps. The operand bits are first copied into work cells, because an implication overwrites its target.

The schedule has two stages. In the first stage, one full adder per bit position reduces the three operand bits to a sum bit and a saved carry bit. No carry passes between positions in this stage. In the second stage, a ripple chain adds the saved carries, shifted up by one position, to the sums. This chain is one half adder, then full adders, then a final half adder, and it produces the result.

A caller raises `start` while the block is idle. The block then holds `busy` for the whole schedule and pulses `done` once. The result is valid from the `done` cycle and stays unchanged until the next run completes.

Top module: `imply_csa_adder`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `sum_out` is 0.
- R2: A `start` sampled high while `busy` is low is accepted: the operands are captured on that edge, and `busy` is 1 in the following cycle.
- R3: With the default width of 3, an accepted run keeps `busy` high for exactly 151 consecutive cycles: 31 steps for each of the four full adders, 13 steps for each of the two half adders, and one commit cycle.
- R4: `done` is high for exactly one cycle. That cycle is the first cycle in which `busy` is low again after a run.
- R5: In the `done` cycle, `sum_out` (bit 0 = LSB, width = operand width + 2) equals the unsigned sum of the three captured operands, for every combination of 3-bit operands.
- R6: `sum_out` changes only at the edge that raises `done`. It holds its value while idle and throughout a later run.
- R7: A `start` sampled while `busy` is high is ignored. The run in progress neither restarts nor lengthens.
- R8: Changes on `a_in`, `b_in` and `c_in` after a run has been accepted have no effect on that run's result.
- R9: `busy` and `done` are never high in the same cycle.
- R10: A `start` presented during the `done` cycle is accepted, so runs can follow each other back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a run; accepted only while idle |
| a_in | input | OPW (3) | First operand, unsigned |
| b_in | input | OPW (3) | Second operand, unsigned |
| c_in | input | OPW (3) | Third operand, unsigned |
| busy | output | 1 | High while the schedule is executing |
| done | output | 1 | One-cycle pulse when the result is committed |
| sum_out | output | OPW+2 (5) | Registered sum, held between completions |

## Verification
The assertions check the following on every cycle:
- the handshake: `busy` and `done` are mutually exclusive, `done` lasts one cycle, and an idle `start` is accepted;
- that each run lasts exactly the schedule length, measured with a counter, even when `start` is pulsed mid-run;
- that `sum_out` changes only together with `done`;
- that the committed sum matches the operands captured at acceptance.

The scenarios then have to show the arithmetic itself. Every one of the 512 operand combinations runs through the full implication schedule. The operands are scrambled after capture, some runs receive a mid-run `start`, and each run begins in the `done` cycle of the one before it.

// File: rtl/imply_csa_pkg.sv
package imply_csa_pkg;

  // Operation applied to the cell bank in one step.
  typedef enum logic [1:0] {
    IK_NOP = 2'd0,
    IK_CLR = 2'd1,   // clear cells src..dst inclusive
    IK_IMP = 2'd2    // cell[dst] <= ~cell[src] | cell[dst]
  } imp_kind_e;

  typedef struct packed {
    imp_kind_e kind;
    int        src;
    int        dst;
  } imp_op_t;

  // Gadget footprints (cells) and lengths (steps).
  localparam int XOR_CELLS = 5;
  localparam int AND_CELLS = 2;
  localparam int OR_CELLS  = 3;
  localparam int XOR_STEPS = 9;
  localparam int AND_STEPS = 4;
  localparam int OR_STEPS  = 5;
  localparam int HA_CELLS  = XOR_CELLS + AND_CELLS;
  localparam int FA_CELLS  = 2 * XOR_CELLS + 2 * AND_CELLS + OR_CELLS;
  localparam int HA_STEPS  = XOR_STEPS + AND_STEPS;
  localparam int FA_STEPS  = 2 * XOR_STEPS + 2 * AND_STEPS + OR_STEPS;

  // ---------------- cell map ----------------
  function automatic int in_cell(int pos, int k);
    return pos * 3 + k;
  endfunction

  function automatic int fa_count(int w);
    return 2 * w - 2;
  endfunction

  function automatic int fa_base(int w, int f);
    return 3 * w + f * FA_CELLS;
  endfunction

  function automatic int ha_base(int w, int h);
    return 3 * w + fa_count(w) * FA_CELLS + h * HA_CELLS;
  endfunction

  function automatic int n_cells(int w);
    return 3 * w + fa_count(w) * FA_CELLS + 2 * HA_CELLS;
  endfunction

  function automatic int n_steps(int w);
    return fa_count(w) * FA_STEPS + 2 * HA_STEPS;
  endfunction

  function automatic int fa_sum(int w, int f);
    return fa_base(w, f) + 11;
  endfunction

  function automatic int fa_carry(int w, int f);
    return fa_base(w, f) + 16;
  endfunction

  function automatic int ha_sum(int w, int h);
    return ha_base(w, h) + 4;
  endfunction

  function automatic int ha_carry(int w, int h);
    return ha_base(w, h) + 6;
  endfunction

  // Ripple carry entering result position j (j >= 2).
  function automatic int carry_in(int w, int j);
    if (j == 2) return ha_carry(w, 0);
    return fa_carry(w, w + j - 3);
  endfunction

  // Cell holding result bit j.
  function automatic int res_cell(int w, int j);
    if (j == 0)     return fa_sum(w, 0);
    if (j == 1)     return ha_sum(w, 0);
    if (j < w)      return fa_sum(w, w + j - 2);
    if (j == w)     return ha_sum(w, 1);
    return ha_carry(w, 1);
  endfunction

  // ---------------- gadget step generators ----------------
  function automatic imp_op_t mk(imp_kind_e k, int s, int d);
    imp_op_t o;
    o.kind = k;
    o.src  = s;
    o.dst  = d;
    return o;
  endfunction

  // out(base+4) = p ^ q ; copies of p and q go through base+0/base+1 into base+2/base+3
  function automatic imp_op_t xor_op(int p, int q, int base, int k);
    case (k)
      0:       return mk(IK_CLR, base, base + 4);
      1:       return mk(IK_IMP, p, base);
      2:       return mk(IK_IMP, base, base + 2);
      3:       return mk(IK_IMP, q, base + 1);
      4:       return mk(IK_IMP, base + 1, base + 3);
      5:       return mk(IK_IMP, p, base + 3);
      6:       return mk(IK_IMP, q, base + 2);
      7:       return mk(IK_IMP, base + 2, base + 4);
      default: return mk(IK_IMP, base + 3, base + 4);
    endcase
  endfunction

  // out(base+1) = p & q
  function automatic imp_op_t and_op(int p, int q, int base, int k);
    case (k)
      0:       return mk(IK_CLR, base, base + 1);
      1:       return mk(IK_IMP, q, base);
      2:       return mk(IK_IMP, p, base);
      default: return mk(IK_IMP, base, base + 1);
    endcase
  endfunction

  // out(base+2) = x | y
  function automatic imp_op_t or_op(int x, int y, int base, int k);
    case (k)
      0:       return mk(IK_CLR, base, base + 2);
      1:       return mk(IK_IMP, x, base);
      2:       return mk(IK_IMP, y, base + 1);
      3:       return mk(IK_IMP, base + 1, base + 2);
      default: return mk(IK_IMP, base, base + 2);
    endcase
  endfunction

  function automatic imp_op_t ha_op(int p, int q, int base, int k);
    if (k < XOR_STEPS) return xor_op(p, q, base, k);
    return and_op(p, q, base + XOR_CELLS, k - XOR_STEPS);
  endfunction

  // sum at base+11, carry at base+16
  function automatic imp_op_t fa_op(int p, int q, int r, int base, int k);
    if (k < 9)  return xor_op(p, q, base, k);
    if (k < 13) return and_op(p, q, base + 5, k - 9);
    if (k < 22) return xor_op(base + 4, r, base + 7, k - 13);
    if (k < 26) return and_op(base + 4, r, base + 12, k - 22);
    return or_op(base + 6, base + 13, base + 14, k - 26);
  endfunction

endpackage

// File: rtl/imply_csa_ctrl.sv
module imply_csa_ctrl
  import imply_csa_pkg::*;
#(
  parameter int OPW = 3
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start,
  output logic                                    busy,
  output logic                                    done,
  output logic [$clog2(n_steps(OPW)+1)-1:0]       step,
  output logic                                    exec,
  output logic                                    load_en,
  output logic                                    commit
);

  localparam int NSTEPS = n_steps(OPW);
  localparam int SW     = $clog2(NSTEPS + 1);
  localparam logic [SW-1:0] LAST = SW'(NSTEPS);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [SW-1:0] step_q, step_d;

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        step_d = '0;
      end
    end else if (step_q == LAST) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      step_d = '0;
    end else begin
      step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      step_q <= step_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign step    = step_q;
  assign load_en = start && !busy_q;
  assign exec    = busy_q && (step_q != LAST);
  assign commit  = busy_q && (step_q == LAST);

endmodule

// File: rtl/imply_csa_sched.sv
module imply_csa_sched
  import imply_csa_pkg::*;
#(
  parameter int OPW = 3
) (
  input  logic [$clog2(n_steps(OPW)+1)-1:0] step,
  input  logic                              exec,
  output imp_kind_e                         kind,
  output logic [$clog2(n_cells(OPW))-1:0]   src,
  output logic [$clog2(n_cells(OPW))-1:0]   dst
);

  localparam int NCELLS = n_cells(OPW);
  localparam int CW     = $clog2(NCELLS);
  localparam int NSTEPS = n_steps(OPW);

  typedef struct packed {
    imp_kind_e     kind;
    logic [CW-1:0] src;
    logic [CW-1:0] dst;
  } op_t;

  typedef op_t [NSTEPS-1:0] prog_t;

  function automatic op_t narrow(imp_op_t o);
    op_t n;
    n.kind = o.kind;
    n.src  = CW'(o.src);
    n.dst  = CW'(o.dst);
    return n;
  endfunction

  // Carry-save row first, then the ripple chain from LSB upward.
  function automatic prog_t build_prog();
    prog_t pr;
    int    idx;
    pr  = '0;
    idx = 0;
    for (int f = 0; f < OPW; f++) begin
      for (int k = 0; k < FA_STEPS; k++) begin
        pr[idx] = narrow(fa_op(in_cell(f, 0), in_cell(f, 1), in_cell(f, 2),
                               fa_base(OPW, f), k));
        idx++;
      end
    end
    for (int k = 0; k < HA_STEPS; k++) begin
      pr[idx] = narrow(ha_op(fa_sum(OPW, 1), fa_carry(OPW, 0), ha_base(OPW, 0), k));
      idx++;
    end
    for (int j = 2; j < OPW; j++) begin
      for (int k = 0; k < FA_STEPS; k++) begin
        pr[idx] = narrow(fa_op(fa_sum(OPW, j), fa_carry(OPW, j - 1), carry_in(OPW, j),
                               fa_base(OPW, OPW + j - 2), k));
        idx++;
      end
    end
    for (int k = 0; k < HA_STEPS; k++) begin
      pr[idx] = narrow(ha_op(fa_carry(OPW, OPW - 1), carry_in(OPW, OPW),
                             ha_base(OPW, 1), k));
      idx++;
    end
    return pr;
  endfunction

  localparam prog_t PROG = build_prog();

  op_t cur;

  always_comb begin
    if (exec) cur = PROG[step];
    else      cur = '0;
  end

  assign kind = cur.kind;
  assign src  = cur.src;
  assign dst  = cur.dst;

endmodule

// File: rtl/imply_cell_bank.sv
module imply_cell_bank
  import imply_csa_pkg::*;
#(
  parameter int OPW = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load_en,
  input  logic [3*OPW-1:0]                  load_bits,
  input  imp_kind_e                         kind,
  input  logic [$clog2(n_cells(OPW))-1:0]   src,
  input  logic [$clog2(n_cells(OPW))-1:0]   dst,
  output logic [n_cells(OPW)-1:0]           cells
);

  localparam int NCELLS = n_cells(OPW);
  localparam int CW     = $clog2(NCELLS);
  localparam int NIN    = 3 * OPW;

  logic [NCELLS-1:0] cells_q;
  logic              src_bit;

  assign src_bit = cells_q[src];

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    logic ld_hit, ld_bit, clr_hit, imp_hit, cell_en, cell_d;

    if (i < NIN) begin : g_in
      assign ld_hit = load_en;
      assign ld_bit = load_bits[i];
    end else begin : g_work
      assign ld_hit = 1'b0;
      assign ld_bit = 1'b0;
    end

    assign clr_hit = (kind == IK_CLR) && (src <= CW'(i)) && (dst >= CW'(i));
    assign imp_hit = (kind == IK_IMP) && (dst == CW'(i));

    always_comb begin
      cell_en = ld_hit || clr_hit || imp_hit;
      if (ld_hit)       cell_d = ld_bit;
      else if (clr_hit) cell_d = 1'b0;
      else              cell_d = ~src_bit | cells_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cells_q[i] <= 1'b0;
      else if (cell_en) cells_q[i] <= cell_d;
    end
  end

  assign cells = cells_q;

endmodule

// File: rtl/imply_csa_adder.sv
module imply_csa_adder
  import imply_csa_pkg::*;
#(
  parameter int OPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] a_in,
  input  logic [OPW-1:0] b_in,
  input  logic [OPW-1:0] c_in,
  output logic           busy,
  output logic           done,
  output logic [OPW+1:0] sum_out
);

  localparam int NCELLS = n_cells(OPW);
  localparam int CW     = $clog2(NCELLS);
  localparam int NSTEPS = n_steps(OPW);
  localparam int SW     = $clog2(NSTEPS + 1);
  localparam int RW     = OPW + 2;

  logic [SW-1:0]     step;
  logic              exec, load_en, commit;
  imp_kind_e         kind;
  logic [CW-1:0]     src, dst;
  logic [NCELLS-1:0] cells;
  logic [3*OPW-1:0]  load_bits;
  logic [RW-1:0]     res_bits;
  logic [RW-1:0]     sum_q;

  for (genvar p = 0; p < OPW; p++) begin : g_load
    assign load_bits[in_cell(p, 0)] = a_in[p];
    assign load_bits[in_cell(p, 1)] = b_in[p];
    assign load_bits[in_cell(p, 2)] = c_in[p];
  end

  for (genvar j = 0; j < RW; j++) begin : g_res
    assign res_bits[j] = cells[res_cell(OPW, j)];
  end

  imply_csa_ctrl #(.OPW(OPW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .step    (step),
    .exec    (exec),
    .load_en (load_en),
    .commit  (commit)
  );

  imply_csa_sched #(.OPW(OPW)) u_sched (
    .step (step),
    .exec (exec),
    .kind (kind),
    .src  (src),
    .dst  (dst)
  );

  imply_cell_bank #(.OPW(OPW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_bits (load_bits),
    .kind      (kind),
    .src       (src),
    .dst       (dst),
    .cells     (cells)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (commit) sum_q <= res_bits;
  end

  assign sum_out = sum_q;

endmodule

// File: rtl/imply_csa_chk.sv
module imply_csa_chk
  import imply_csa_pkg::*;
#(
  parameter int OPW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [OPW-1:0] a_in,
  input logic [OPW-1:0] b_in,
  input logic [OPW-1:0] c_in,
  input logic           busy,
  input logic           done,
  input logic [OPW+1:0] sum_out
);

  localparam int LAT = n_steps(OPW) + 1;
  localparam int RLW = $clog2(LAT + 1) + 1;

  logic [RLW-1:0] run_len_q;
  logic [OPW+1:0] exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len_q <= '0;
    else if (busy) run_len_q <= run_len_q + 1'b1;
    else           run_len_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                exp_q <= '0;
    else if (start && !busy)   exp_q <= {2'b00, a_in} + {2'b00, b_in} + {2'b00, c_in};
  end

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len_q == RLW'(LAT)));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  // R5
  result_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sum_out == exp_q));

  // R6
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sum_out) |-> done);

endmodule

bind imply_csa_adder imply_csa_chk #(.OPW(OPW)) u_imply_csa_chk (.*);

// File: tb/test_imply_csa_adder.sv
module test_imply_csa_adder;

  localparam int CLK_PERIOD = 10;
  localparam int OPW        = 3;
  localparam int LAT        = 151;   // R3: 4*31 + 2*13 + 1
  localparam int WATCHDOG   = 190000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [OPW-1:0] a_in, b_in, c_in;
  logic           busy, done;
  logic [OPW+1:0] sum_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  // reference model state
  bit m_busy, m_done;
  int m_cnt, m_exp, m_sum;

  always #(CLK_PERIOD/2) clk = ~clk;

  imply_csa_adder #(.OPW(OPW)) i_imply_csa_adder (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .busy(busy), .done(done), .sum_out(sum_out)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_exp = 0; m_sum = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        if (m_cnt == LAT) begin
          m_busy = 1'b0; m_done = 1'b1; m_sum = m_exp;
        end else begin
          m_cnt++;
        end
      end else if (start) begin
        m_busy = 1'b1; m_cnt = 1; m_exp = int'(a_in) + int'(b_in) + int'(c_in);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      check(busy === m_busy, "R3 busy vs model", int'(busy), int'(m_busy));
      check(done === m_done, "R4 done vs model", int'(done), int'(m_done));
      check(int'(sum_out) == m_sum, "R6 held sum vs model", int'(sum_out), m_sum);
      check(!(busy && done), "R9 busy and done exclusive", int'(busy && done), 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_one(int x, int y, int z, int idx);
    bit prev_done;
    int nbusy, guard;
    prev_done = done;
    a_in = OPW'(x); b_in = OPW'(y); c_in = OPW'(z); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (prev_done) check(busy === 1'b1, "R10 start in done cycle", int'(busy), 1);
    else           check(busy === 1'b1, "R2 start accepted", int'(busy), 1);
    // R8: scramble operands after capture
    a_in = ~OPW'(x); b_in = OPW'(y + 3); c_in = ~OPW'(z);
    nbusy = 1;
    guard = 0;
    while (!done && guard < 1000) begin
      start = (idx % 8 == 3 && (nbusy == 20 || nbusy == LAT - 1));
      @(negedge clk);
      if (busy) nbusy++;
      guard++;
    end
    start = 1'b0;
    if (idx % 8 == 3) check(nbusy == LAT, "R7 mid-run start ignored", nbusy, LAT);
    else              check(nbusy == LAT, "R3 run length", nbusy, LAT);
    check(int'(sum_out) == x + y + z, "R5 R8 sum of captured operands",
          int'(sum_out), x + y + z);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; a_in = '0; b_in = '0; c_in = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    check(done === 1'b0, "R1 done in reset", int'(done), 0);
    check(sum_out === '0, "R1 sum in reset", int'(sum_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 idle after reset", int'({busy, done}), 0);
    check(sum_out === '0, "R1 sum after reset", int'(sum_out), 0);
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++)
        for (int z = 0; z < 8; z++)
          run_one(x, y, z, x * 64 + y * 8 + z);
    repeat (3) @(negedge clk);
    check(int'(sum_out) == 21, "R6 sum held while idle", int'(sum_out), 21);
    ended = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule